// File: doc/BRIEF.md
# Multiplexed DRAM Strobe Command Decoder

This block is the control front end of a multiplexed-address DRAM device, modelled as synchronous logic. The four active-low strobes (row strobe, column strobe, write enable, output enable) and the shared address bus arrive from the pins. They pass through a synchroniser and are compared against their previous values to find falling and rising edges. Each strobe edge is then classified by what the other strobes are doing at that moment. The result is a one-cycle operation code, together with the latched row and column addresses.

The order in which the two address strobes fall decides the kind of cycle:
- Row strobe falling while the column strobe is high opens a row from the pins.
- Row strobe falling while the column strobe is already low starts an internally addressed refresh, or enters test mode when write enable is low.
- Column strobe falling inside an open row selects a read or a write, and repeated column edges give page-mode accesses.

An internal row counter supplies the refresh row for column-first and hidden refreshes, and advances after each of them. A data-bus output enable is held while a read is outstanding, including across a hidden refresh.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, `op_o` is 0 (no operation), `dq_oe_o` and `test_mode_o` are 0, and `row_o`, `col_o` and `refresh_row_o` are 0.
- R2: Every strobe and address pin passes through `SYNC_STAGES` flip-flops before edge detection. With the default of 2, an operation appears on `op_o` at the third clock edge after the pin change and lasts exactly one cycle.
- R3: A row strobe fall while the column strobe is high produces code 1 (row open) and latches the address into `row_o`.
- R4: A column strobe fall inside an open row latches the low `COL_W` address bits into `col_o`, and every such fall in the same row latches a new column. It then gives code 3 (write) when write enable is low, or code 2 (read) when write enable is high and output enable is low. With both high, no code is produced.
- R5: A row strobe rise that closes a row with no column strobe fall since it opened produces code 4 (row-only refresh), and `refresh_row_o` equals the latched row.
- R6: A row strobe fall with the column strobe low, write enable high and no held access produces code 5 (column-first refresh). `refresh_row_o` takes the internal counter value, and the counter then advances by one, wrapping from all ones to 0.
- R7: A row strobe fall with the column strobe held low since a read or write in a previous row produces code 6 (hidden refresh). It uses and advances the counter like R6, and `dq_oe_o` stays high when the held access was a read.
- R8: A row strobe fall with the column strobe low, write enable low and no held access produces code 7 (test entry) and sets `test_mode_o`.
- R9: `test_mode_o` clears on a code-4 refresh with write enable high, or on a code-5 refresh. It stays set through a code-4 refresh with write enable low.
- R10: `dq_oe_o` is high only while a read is held and output enable is low. It clears when the column strobe rises, so it is low in standby.
- R11: A column strobe fall while no row is open produces no code and leaves `col_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row address strobe, active low |
| cas_n | input | 1 | Column address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| op_o | output | 3 | One-cycle decoded operation code (0 none, 1 to 7 per R3 to R8) |
| row_o | output | ROW_W | Latched row address |
| col_o | output | COL_W | Latched column address |
| refresh_row_o | output | ROW_W | Row refreshed by the last refresh operation |
| dq_oe_o | output | 1 | Data bus drive enable |
| test_mode_o | output | 1 | Test mode flag |

## Verification
The bench builds the decoder with a 4-bit row and a 3-bit column. This makes the refresh counter wrap after sixteen internally addressed refreshes, which puts the R6 wrap within a short run of directed and random refresh cycles. The narrow address also lets random row and column values repeat and cover the extreme codes. The synchroniser depth stays at its default of two so that the three-edge latency of R2 is measured exactly.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

   typedef enum logic [2:0] {
      OP_NONE       = 3'd0,
      OP_ROW_ACT    = 3'd1,
      OP_READ       = 3'd2,
      OP_WRITE      = 3'd3,
      OP_RAS_REF    = 3'd4,
      OP_CBR_REF    = 3'd5,
      OP_HIDDEN_REF = 3'd6,
      OP_TEST_ENTRY = 3'd7
   } dram_op_e;

   localparam int EDGE_N  = 2;
   localparam int IDX_RAS = 0;
   localparam int IDX_CAS = 1;

endpackage

// File: rtl/dsd_sync_pipe.sv
module dsd_sync_pipe #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= RST_VAL;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/dsd_edge_detect.sv
module dsd_edge_detect #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_n,
   output logic [W-1:0] lvl,
   output logic [W-1:0] fall,
   output logic [W-1:0] rise
);

   logic [W-1:0] prev;

   dsd_sync_pipe #(.W(W), .STAGES(STAGES), .RST_VAL({W{1'b1}})) u_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_n),
      .dout (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= lvl;
   end

   assign fall = prev & ~lvl;
   assign rise = ~prev & lvl;

endmodule

// File: rtl/dsd_refresh_counter.sv
module dsd_refresh_counter #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + ONE;
   end

endmodule

// File: rtl/dsd_cycle_classifier.sv
module dsd_cycle_classifier
   import dsd_pkg::*;
#(
   parameter int ROW_W = 13,
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_fall,
   input  logic             ras_rise,
   input  logic             cas_fall,
   input  logic             cas_rise,
   input  logic             cas_lvl,
   input  logic             we_lvl,
   input  logic             oe_lvl,
   input  logic [ROW_W-1:0] addr_s,
   input  logic [ROW_W-1:0] cnt,
   output logic             cnt_inc,
   output dram_op_e         op_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o,
   output logic [ROW_W-1:0] refresh_row_o,
   output logic             dq_oe_o,
   output logic             test_mode_o
);

   logic row_active;
   logic col_seen;
   logic acc_hold;
   logic rd_hold;

   // internal-counter refresh: column strobe already low at row fall
   assign cnt_inc = ras_fall & ~cas_lvl & (acc_hold | we_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_o          <= OP_NONE;
         row_o         <= '0;
         col_o         <= '0;
         refresh_row_o <= '0;
         row_active    <= 1'b0;
         col_seen      <= 1'b0;
         acc_hold      <= 1'b0;
         rd_hold       <= 1'b0;
         test_mode_o   <= 1'b0;
      end else begin
         op_o <= OP_NONE;
         if (ras_fall) begin
            if (cas_lvl) begin
               op_o       <= OP_ROW_ACT;
               row_o      <= addr_s;
               row_active <= 1'b1;
               col_seen   <= 1'b0;
            end else if (acc_hold) begin
               op_o          <= OP_HIDDEN_REF;
               refresh_row_o <= cnt;
            end else if (we_lvl) begin
               op_o          <= OP_CBR_REF;
               refresh_row_o <= cnt;
               test_mode_o   <= 1'b0;
            end else begin
               op_o        <= OP_TEST_ENTRY;
               test_mode_o <= 1'b1;
            end
         end else if (ras_rise) begin
            if (row_active && !col_seen) begin
               op_o          <= OP_RAS_REF;
               refresh_row_o <= row_o;
               if (we_lvl) test_mode_o <= 1'b0;
            end
            row_active <= 1'b0;
         end else if (cas_fall && row_active) begin
            col_o    <= addr_s[COL_W-1:0];
            col_seen <= 1'b1;
            if (!we_lvl) begin
               op_o     <= OP_WRITE;
               acc_hold <= 1'b1;
            end else if (!oe_lvl) begin
               op_o     <= OP_READ;
               acc_hold <= 1'b1;
               rd_hold  <= 1'b1;
            end
         end
         if (cas_rise) begin
            acc_hold <= 1'b0;
            rd_hold  <= 1'b0;
         end
      end
   end

   assign dq_oe_o = rd_hold & ~oe_lvl;

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
   import dsd_pkg::*;
#(
   parameter int ROW_W       = 13,
   parameter int COL_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [ROW_W-1:0] addr,
   output logic [2:0]       op_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o,
   output logic [ROW_W-1:0] refresh_row_o,
   output logic             dq_oe_o,
   output logic             test_mode_o
);

   localparam int LVL_W = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (COL_W > ROW_W || COL_W < 1) begin : g_bad_col
         $error("COL_W must be in 1..ROW_W");
      end
      if (ROW_W < 2 || ROW_W > 16) begin : g_bad_row
         $error("ROW_W must be in 2..16");
      end
   endgenerate

   logic [EDGE_N-1:0] strb_lvl, strb_fall, strb_rise;
   logic [LVL_W-1:0]  ctl_lvl;
   logic [ROW_W-1:0]  addr_s;
   logic [ROW_W-1:0]  ref_cnt;
   logic              cnt_inc;
   dram_op_e          op_e;

   dsd_edge_detect #(.W(EDGE_N), .STAGES(SYNC_STAGES)) u_edges (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_n({cas_n, ras_n}),
      .lvl  (strb_lvl),
      .fall (strb_fall),
      .rise (strb_rise)
   );

   dsd_sync_pipe #(.W(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL({LVL_W{1'b1}})) u_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({oe_n, we_n}),
      .dout (ctl_lvl)
   );

   dsd_sync_pipe #(.W(ROW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (addr),
      .dout (addr_s)
   );

   dsd_refresh_counter #(.W(ROW_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc),
      .count(ref_cnt)
   );

   dsd_cycle_classifier #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
      .clk          (clk),
      .rst_n        (rst_n),
      .ras_fall     (strb_fall[IDX_RAS]),
      .ras_rise     (strb_rise[IDX_RAS]),
      .cas_fall     (strb_fall[IDX_CAS]),
      .cas_rise     (strb_rise[IDX_CAS]),
      .cas_lvl      (strb_lvl[IDX_CAS]),
      .we_lvl       (ctl_lvl[0]),
      .oe_lvl       (ctl_lvl[1]),
      .addr_s       (addr_s),
      .cnt          (ref_cnt),
      .cnt_inc      (cnt_inc),
      .op_o         (op_e),
      .row_o        (row_o),
      .col_o        (col_o),
      .refresh_row_o(refresh_row_o),
      .dq_oe_o      (dq_oe_o),
      .test_mode_o  (test_mode_o)
   );

   assign op_o = op_e;

endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk
   import dsd_pkg::*;
#(
   parameter int ROW_W = 13,
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       op_o,
   input logic [ROW_W-1:0] row_o,
   input logic [COL_W-1:0] col_o,
   input logic [ROW_W-1:0] refresh_row_o,
   input logic             dq_oe_o,
   input logic             test_mode_o,
   input logic [1:0]       strb_lvl,
   input logic [1:0]       strb_rise,
   input logic [ROW_W-1:0] cnt,
   input logic             cnt_inc
);

   // R2
   op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o != 3'(OP_NONE)) |=> (op_o != $past(op_o)));

   // R5
   ras_ref_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o == 3'(OP_RAS_REF)) |-> (refresh_row_o == row_o));

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_inc |=> (cnt == $past(cnt) + 1'b1));

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_inc |=> $stable(cnt));

   // R8
   tmode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_mode_o) |-> (op_o == 3'(OP_TEST_ENTRY)));

   // R9
   tmode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(test_mode_o) |-> (op_o == 3'(OP_RAS_REF) || op_o == 3'(OP_CBR_REF)));

   // R10
   standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_lvl[1] && !strb_rise[1]) |-> !dq_oe_o);

   // R11
   col_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_lvl[0] && strb_lvl[1] && $past(strb_lvl[0])) |=> $stable(col_o));

endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_o         (op_o),
   .row_o        (row_o),
   .col_o        (col_o),
   .refresh_row_o(refresh_row_o),
   .dq_oe_o      (dq_oe_o),
   .test_mode_o  (test_mode_o),
   .strb_lvl     (strb_lvl),
   .strb_rise    (strb_rise),
   .cnt          (ref_cnt),
   .cnt_inc      (cnt_inc)
);

// File: tb/dram_strobe_decoder_test.sv
module dram_strobe_decoder_test;
   import dsd_pkg::*;

   localparam int RW = 4;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [RW-1:0] addr = '0;
   logic [2:0]    op_o;
   logic [RW-1:0] row_o, refresh_row_o;
   logic [CW-1:0] col_o;
   logic          dq_oe_o, test_mode_o;

   int nchk = 0, nfail = 0, npulse = 0;
   logic [2:0]    seen_op = 3'd0;
   logic [RW-1:0] exp_cnt = '0;
   bit            exp_tm = 1'b0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   dram_strobe_decoder #(.ROW_W(RW), .COL_W(CW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .op_o(op_o), .row_o(row_o), .col_o(col_o),
      .refresh_row_o(refresh_row_o), .dq_oe_o(dq_oe_o), .test_mode_o(test_mode_o)
   );

   always @(negedge clk) begin
      if (rst_n && op_o != 3'(OP_NONE)) begin
         npulse++;
         seen_op = op_o;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input logic r, input logic c, input logic w, input logic o,
                        input logic [RW-1:0] a);
      npulse  = 0;
      seen_op = 3'(OP_NONE);
      ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
      repeat (6) @(negedge clk);
   endtask

   task automatic expect_op(input string req, input dram_op_e e);
      chk({req, " op"}, int'(seen_op), int'(e));
      chk({req, " pulses"}, npulse, (e == OP_NONE) ? 0 : 1);
      chk({req, " test_mode"}, int'(test_mode_o), int'(exp_tm));
   endtask

   function automatic dram_op_e col_op(input bit wr, input bit oe_hi);
      if (wr) return OP_WRITE;
      return oe_hi ? OP_NONE : OP_READ;
   endfunction

   task automatic open_row(input logic [RW-1:0] r);
      apply(0, 1, 1, 1, r);
      expect_op("R3", OP_ROW_ACT);
      chk("R3 row", int'(row_o), int'(r));
   endtask

   task automatic col_access(input logic [CW-1:0] c, input bit wr, input bit oe_hi);
      apply(0, 0, wr ? 1'b0 : 1'b1, oe_hi, RW'(c));
      expect_op("R4", col_op(wr, oe_hi));
      chk("R4 col", int'(col_o), int'(c));
      chk("R10 dq_oe read", int'(dq_oe_o), (!wr && !oe_hi) ? 1 : 0);
      apply(0, 1, 1, 1, '0);
      expect_op("R10 cas rise", OP_NONE);
      chk("R10 dq_oe off", int'(dq_oe_o), 0);
   endtask

   task automatic close_row(input bit used);
      apply(1, 1, 1, 1, '0);
      expect_op("R5 close", used ? OP_NONE : OP_RAS_REF);
   endtask

   task automatic ras_only(input logic [RW-1:0] r, input bit we_hi);
      apply(0, 1, we_hi, 1, r);
      expect_op("R3", OP_ROW_ACT);
      if (we_hi) exp_tm = 1'b0;
      apply(1, 1, we_hi, 1, r);
      expect_op("R5 R9", OP_RAS_REF);
      chk("R5 refresh row", int'(refresh_row_o), int'(r));
      apply(1, 1, 1, 1, '0);
   endtask

   task automatic cbr();
      logic [CW-1:0] c0;
      c0 = col_o;
      apply(1, 0, 1, 1, RW'($urandom));
      expect_op("R11", OP_NONE);
      chk("R11 col kept", int'(col_o), int'(c0));
      exp_tm = 1'b0;
      apply(0, 0, 1, 1, '0);
      expect_op("R6", OP_CBR_REF);
      chk("R6 refresh row", int'(refresh_row_o), int'(exp_cnt));
      exp_cnt = exp_cnt + 1'b1;
      apply(1, 0, 1, 1, '0);
      expect_op("R6 rise", OP_NONE);
      apply(1, 1, 1, 1, '0);
   endtask

   task automatic hidden(input logic [RW-1:0] r, input logic [CW-1:0] c, input bit wr);
      open_row(r);
      apply(0, 0, wr ? 1'b0 : 1'b1, wr ? 1'b1 : 1'b0, RW'(c));
      expect_op("R4", wr ? OP_WRITE : OP_READ);
      apply(1, 0, 1, wr ? 1'b1 : 1'b0, '0);
      expect_op("R7 rise", OP_NONE);
      apply(0, 0, 1, wr ? 1'b1 : 1'b0, '0);
      expect_op("R7", OP_HIDDEN_REF);
      chk("R7 refresh row", int'(refresh_row_o), int'(exp_cnt));
      chk("R7 dq held", int'(dq_oe_o), wr ? 0 : 1);
      exp_cnt = exp_cnt + 1'b1;
      apply(1, 0, 1, 1, '0);
      apply(1, 1, 1, 1, '0);
      chk("R10 standby", int'(dq_oe_o), 0);
   endtask

   task automatic test_entry();
      apply(1, 0, 0, 1, '0);
      expect_op("R8 pre", OP_NONE);
      exp_tm = 1'b1;
      apply(0, 0, 0, 1, '0);
      expect_op("R8", OP_TEST_ENTRY);
      apply(1, 0, 1, 1, '0);
      apply(1, 1, 1, 1, '0);
      expect_op("R8 idle", OP_NONE);
   endtask

   initial begin
      int lat;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 op", int'(op_o), 0);
      chk("R1 dq_oe", int'(dq_oe_o), 0);
      chk("R1 test_mode", int'(test_mode_o), 0);
      chk("R1 rows", int'(row_o) + int'(refresh_row_o) + int'(col_o), 0);

      // R2 latency: three edges after the pin change
      lat = 0;
      ras_n = 1'b0; addr = 4'd9;
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         if (lat == 0 && op_o != 3'(OP_NONE)) lat = i;
      end
      chk("R2 latency", lat, 3);
      chk("R3 row", int'(row_o), 9);
      apply(1, 1, 1, 1, '0);
      expect_op("R5 after latency", OP_RAS_REF);

      // page mode: read, write, column-only latch
      open_row(4'd5);
      col_access(3'd2, 1'b0, 1'b0);
      col_access(3'd7, 1'b1, 1'b1);
      col_access(3'd4, 1'b0, 1'b1);
      close_row(1'b1);

      ras_only(4'd12, 1'b1);
      cbr();
      hidden(4'd3, 3'd6, 1'b0);
      hidden(4'd8, 3'd1, 1'b1);

      test_entry();
      ras_only(4'd2, 1'b0);
      chk("R9 kept", int'(test_mode_o), 1);
      ras_only(4'd2, 1'b1);
      chk("R9 cleared", int'(test_mode_o), 0);
      test_entry();
      cbr();
      chk("R9 cbr clears", int'(test_mode_o), 0);

      // R6 wrap: run the counter past all ones
      for (int k = 0; k < 17; k++) cbr();

      // random mix
      for (int it = 0; it < 40; it++) begin
         case ($urandom_range(0, 4))
            0: begin
               int n = $urandom_range(1, 3);
               open_row(RW'($urandom));
               for (int j = 0; j < n; j++)
                  col_access(CW'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
               close_row(1'b1);
            end
            1: ras_only(RW'($urandom), bit'($urandom_range(0, 1)));
            2: cbr();
            3: hidden(RW'($urandom), CW'($urandom), bit'($urandom_range(0, 1)));
            default: begin test_entry(); cbr(); end
         endcase
      end

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

endmodule